// File: doc/BRIEF.md
# HDLC Command Register Sequencer

This block sits behind the processor's write port to an HDLC link controller. Each processor write to the command register is decoded into control actions for the receive path, the acknowledgement logic, the supervision timer and the transmit framer. Most bits are one-shot commands that clear themselves after the write. One bit, the receiver-busy selection, is a level that persists until it is written again. Only writes are decoded; the block keeps no readable state.

The framer and the sequence-number logic consume the outputs. A release pulse frees fetched receive FIFO space. A receive reset pulse clears the receiver, and in auto mode it is paired with a sequence-counter clear. A level selects RR or RNR as the acknowledgement type. A timer-run level starts and stops the timer, and a request pulse asks for a polled supervisory command. Transmit start, abort and message-end pulses drive the transmit side, together with held frame-type and header-insertion levels. The transmit side reads frames of up to 32 bytes from its FIFO. Flag insertion, bit stuffing, CRC and line handling belong to the framer.

Top module: `hdlc_cmd_seq`

## Requirements
- R1: After reset every output is 0.
- R2: A write with bit 7 set gives a one-cycle `rx_release` pulse in the cycle after the write.
- R3: A write with bit 6 set pulses `rx_reset` in the next cycle. `seq_clear` pulses with it only if `auto_mode` was 1 at the write.
- R4: In auto mode, every write with a nonzero value loads bit 5 into `ack_rnr` (1 = acknowledge with RNR, 0 = with RR). The new value is visible from the next cycle and holds until the next such write.
- R5: A write made while `auto_mode` is 0 leaves `ack_rnr` unchanged, whatever bit 5 holds.
- R6: A write with bit 4 set sets `timer_run`. If `int_timer_mode` is 1, it also pulses `sframe_req` for one cycle. `sframe_rnr` then takes the `ack_rnr` value that results from that same write, and holds it until the next request.
- R7: `timer_cfg_wr` clears `timer_run` in the next cycle. If a bit-4 write occurs in the same cycle, the timer is set instead.
- R8: A write with bit 3 set and bit 0 clear pulses `tx_start`, with `tx_iframe` and `tx_hdr_ins` both 0 (transparent frame).
- R9: In auto mode, a write with bit 2 set and bit 0 clear pulses `tx_start` with `tx_iframe` and `tx_hdr_ins` both 1. This holds even if bit 3 is also set. Outside auto mode, bit 2 is ignored.
- R10: Bit 0 pulses `tx_reset` and suppresses any `tx_start` from the same write. Bit 1 pulses `tx_msg_end`. `tx_iframe` and `tx_hdr_ins` keep their values until the next started frame.
- R11: Command pulses last exactly one cycle. A cycle without a write leaves every pulse output at 0 and every level output unchanged.
- R12: A write of 0x00 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command value written |
| auto_mode | input | 1 | Link runs in auto (acknowledged) mode |
| int_timer_mode | input | 1 | Timer runs in internal mode (polls on start) |
| timer_cfg_wr | input | 1 | Write to the timer configuration register |
| rx_release | output | 1 | Release fetched receive FIFO space |
| rx_reset | output | 1 | Reset receiver and flush its FIFO |
| seq_clear | output | 1 | Clear send and receive sequence counters |
| ack_rnr | output | 1 | Acknowledge with RNR (1) or RR (0) |
| timer_run | output | 1 | Hardware timer running |
| sframe_req | output | 1 | Request polled supervisory command |
| sframe_rnr | output | 1 | Requested command is RNR (1) or RR (0) |
| tx_start | output | 1 | Start frame transmission |
| tx_iframe | output | 1 | Frame type of last start: I-frame |
| tx_hdr_ins | output | 1 | Insert address and control fields |
| tx_reset | output | 1 | Reset transmitter |
| tx_msg_end | output | 1 | Transmit message end |

## Verification
The bench targets the interaction between the persistent busy level and the one-shot bits. One case is a timer start combined with a busy-bit change in the same write, where a design that sampled the old level would request the wrong supervisory type. Another is a zero write in auto mode: a design that treated it as a real write would wipe the busy level. The bench also covers a transmit abort combined with a start, where a design with the wrong priority would launch a frame. It checks an I-frame command outside auto mode, which must stay inert, and a timer stop combined with a start, where a design with the wrong priority would leave the timer idle. Reset in the middle of a run must return every level to 0.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
   // Command register bit positions (the processor-visible layout)
   localparam int unsigned CMD_W    = 8;
   localparam int unsigned B_RELEAS = 7;
   localparam int unsigned B_RXRST  = 6;
   localparam int unsigned B_BUSY   = 5;
   localparam int unsigned B_TSTART = 4;
   localparam int unsigned B_TRANSP = 3;
   localparam int unsigned B_IFRM   = 2;
   localparam int unsigned B_MEND   = 1;
   localparam int unsigned B_TXRST  = 0;

   typedef struct packed {
      logic releas;
      logic rxrst;
      logic busy;
      logic tstart;
      logic transp;
      logic ifrm;
      logic mend;
      logic txrst;
   } cmd_t;
endpackage

// File: rtl/hcmd_reg.sv
module hcmd_reg #(
   parameter int unsigned W         = 1,
   parameter logic [W-1:0] RST_VAL  = '0,
   parameter bit           ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= RST_VAL;
            else if (en) q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST_VAL;
            else if (en) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/hcmd_rx.sv
module hcmd_rx #(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic cmd_release,
   input  logic cmd_rxrst,
   input  logic cmd_busy,
   input  logic auto_mode,
   output logic rx_release,
   output logic rx_reset,
   output logic seq_clear,
   output logic ack_rnr,
   output logic busy_next
);
   logic busy_load;

   assign busy_load = cmd_valid & auto_mode;
   assign busy_next = busy_load ? cmd_busy : ack_rnr;

   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_rel (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(cmd_release), .q(rx_release));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_rrst (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(cmd_rxrst), .q(rx_reset));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(cmd_rxrst & auto_mode), .q(seq_clear));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_busy (
      .clk(clk), .rst_n(rst_n), .en(busy_load), .d(cmd_busy), .q(ack_rnr));
endmodule

// File: rtl/hcmd_tmr.sv
module hcmd_tmr #(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_tstart,
   input  logic int_timer_mode,
   input  logic timer_cfg_wr,
   input  logic busy_next,
   output logic timer_run,
   output logic sframe_req,
   output logic sframe_rnr
);
   logic run_d;
   logic poll;

   // a start in the same cycle as a stop wins
   assign run_d = cmd_tstart | (timer_run & ~timer_cfg_wr);
   assign poll  = cmd_tstart & int_timer_mode;

   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_run (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(run_d), .q(timer_run));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_req (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(poll), .q(sframe_req));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_kind (
      .clk(clk), .rst_n(rst_n), .en(poll), .d(busy_next), .q(sframe_rnr));
endmodule

// File: rtl/hcmd_tx.sv
module hcmd_tx #(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_mode,
   input  logic cmd_transp,
   input  logic cmd_ifrm,
   input  logic cmd_mend,
   input  logic cmd_txrst,
   output logic tx_start,
   output logic tx_iframe,
   output logic tx_hdr_ins,
   output logic tx_reset,
   output logic tx_msg_end
);
   logic ifrm_ok;
   logic go;

   assign ifrm_ok = cmd_ifrm & auto_mode;
   assign go      = (cmd_transp | ifrm_ok) & ~cmd_txrst;

   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_go (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(go), .q(tx_start));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_type (
      .clk(clk), .rst_n(rst_n), .en(go), .d(ifrm_ok), .q(tx_iframe));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_hdr (
      .clk(clk), .rst_n(rst_n), .en(go), .d(ifrm_ok), .q(tx_hdr_ins));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_xrst (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(cmd_txrst), .q(tx_reset));
   hcmd_reg #(.W(1), .RST_VAL(1'b0), .ASYNC_RST(ASYNC_RST)) u_mend (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(cmd_mend), .q(tx_msg_end));
endmodule

// File: rtl/hdlc_cmd_seq.sv
module hdlc_cmd_seq #(
   parameter int unsigned REG_W     = 8,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             auto_mode,
   input  logic             int_timer_mode,
   input  logic             timer_cfg_wr,
   output logic             rx_release,
   output logic             rx_reset,
   output logic             seq_clear,
   output logic             ack_rnr,
   output logic             timer_run,
   output logic             sframe_req,
   output logic             sframe_rnr,
   output logic             tx_start,
   output logic             tx_iframe,
   output logic             tx_hdr_ins,
   output logic             tx_reset,
   output logic             tx_msg_end
);
   import hcmd_pkg::*;

   generate
      if (REG_W != CMD_W) begin : g_bad_width
         $error("hdlc_cmd_seq: REG_W must equal the command layout width");
      end
   endgenerate

   logic cmd_valid;
   cmd_t cmd;

   // an all-zero write is treated as no write at all
   assign cmd_valid = wr_en & (|wr_data);
   assign cmd       = cmd_valid ? cmd_t'(wr_data[CMD_W-1:0]) : '0;

   hcmd_rx #(.ASYNC_RST(ASYNC_RST)) u_rx (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
      .cmd_release(cmd.releas), .cmd_rxrst(cmd.rxrst), .cmd_busy(cmd.busy),
      .auto_mode(auto_mode), .rx_release(rx_release), .rx_reset(rx_reset),
      .seq_clear(seq_clear), .ack_rnr(ack_rnr), .busy_next(busy_next));

   logic busy_next;

   hcmd_tmr #(.ASYNC_RST(ASYNC_RST)) u_tmr (
      .clk(clk), .rst_n(rst_n), .cmd_tstart(cmd.tstart),
      .int_timer_mode(int_timer_mode), .timer_cfg_wr(timer_cfg_wr),
      .busy_next(busy_next), .timer_run(timer_run),
      .sframe_req(sframe_req), .sframe_rnr(sframe_rnr));

   hcmd_tx #(.ASYNC_RST(ASYNC_RST)) u_tx (
      .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
      .cmd_transp(cmd.transp), .cmd_ifrm(cmd.ifrm), .cmd_mend(cmd.mend),
      .cmd_txrst(cmd.txrst), .tx_start(tx_start), .tx_iframe(tx_iframe),
      .tx_hdr_ins(tx_hdr_ins), .tx_reset(tx_reset), .tx_msg_end(tx_msg_end));
endmodule

// File: rtl/hcmd_chk.sv
module hcmd_chk #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic             auto_mode,
   input logic             int_timer_mode,
   input logic             timer_cfg_wr,
   input logic             rx_release,
   input logic             rx_reset,
   input logic             seq_clear,
   input logic             ack_rnr,
   input logic             timer_run,
   input logic             sframe_req,
   input logic             sframe_rnr,
   input logic             tx_start,
   input logic             tx_iframe,
   input logic             tx_hdr_ins,
   input logic             tx_reset,
   input logic             tx_msg_end
);
   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7]) |=> rx_release);

   p_rxrst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[6]) |=> rx_reset);

   p_seq_with_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seq_clear |-> rx_reset);

   p_busy_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode |=> $stable(ack_rnr));

   p_poll_starts_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sframe_req |-> timer_run);

   p_timer_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_cfg_wr && !(wr_en && wr_data[4])) |=> !timer_run);

   p_iframe_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && tx_iframe) |-> $past(auto_mode));

   p_abort_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0]) |=> (tx_reset && !tx_start));

   p_self_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !(rx_release || rx_reset || sframe_req || tx_start
                   || tx_reset || tx_msg_end));

   p_zero_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == '0) |=> ($stable(ack_rnr) && !tx_start && !rx_reset));
endmodule

bind hdlc_cmd_seq hcmd_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hdlc_cmd_seq_bench.sv
module hdlc_cmd_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       auto_mode = 1'b0;
   logic       int_timer_mode = 1'b0;
   logic       timer_cfg_wr = 1'b0;
   logic rx_release, rx_reset, seq_clear, ack_rnr, timer_run, sframe_req;
   logic sframe_rnr, tx_start, tx_iframe, tx_hdr_ins, tx_reset, tx_msg_end;
   logic [11:0] obs;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hdlc_cmd_seq u_hdlc_cmd_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .auto_mode(auto_mode), .int_timer_mode(int_timer_mode),
      .timer_cfg_wr(timer_cfg_wr), .rx_release(rx_release), .rx_reset(rx_reset),
      .seq_clear(seq_clear), .ack_rnr(ack_rnr), .timer_run(timer_run),
      .sframe_req(sframe_req), .sframe_rnr(sframe_rnr), .tx_start(tx_start),
      .tx_iframe(tx_iframe), .tx_hdr_ins(tx_hdr_ins), .tx_reset(tx_reset),
      .tx_msg_end(tx_msg_end));

   // observed order: release rxrst seq rnr run req srnr start ifr hdr xrst mend
   assign obs = {rx_release, rx_reset, seq_clear, ack_rnr, timer_run, sframe_req,
                 sframe_rnr, tx_start, tx_iframe, tx_hdr_ins, tx_reset, tx_msg_end};

   // {we, data, auto, itm, cfg, expected}
   localparam int NV = 17;
   localparam logic [23:0] VEC [0:NV-1] = '{
      {1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 12'h800},
      {1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 12'h400},
      {1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 12'h600},
      {1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 12'h000},
      {1'b1, 8'h20, 1'b1, 1'b0, 1'b0, 12'h100},
      {1'b1, 8'h30, 1'b1, 1'b1, 1'b0, 12'h1E0},
      {1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 12'h1B0},
      {1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 12'h1A0},
      {1'b1, 8'h0C, 1'b1, 1'b0, 1'b0, 12'h0BC},
      {1'b1, 8'h09, 1'b0, 1'b0, 1'b0, 12'h0AE},
      {1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 12'h0AD},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 12'h02C},
      {1'b1, 8'h10, 1'b0, 1'b0, 1'b1, 12'h0AC},
      {1'b1, 8'h20, 1'b1, 1'b0, 1'b0, 12'h1AC},
      {1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 12'h1AC},
      {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h1AC},
      {1'b1, 8'h10, 1'b0, 1'b1, 1'b0, 12'h1EC}
   };

   function automatic string tag_of(int i);
      case (i)
         0:       return "R2 release";
         1, 2:    return "R3 receiver reset";
         3:       return "R5 busy ignored";
         4, 13:   return "R4 busy load";
         5, 16:   return "R6 timer start";
         6:       return "R8 transparent";
         7, 8:    return "R9 I-frame";
         9, 10:   return "R10 abort/end";
         11, 12:  return "R7 timer stop";
         14:      return "R12 zero write";
         default: return "R11 idle";
      endcase
   endfunction

   task automatic check(string tag, logic [11:0] exp);
      total++;
      if (obs !== exp) begin
         bad++;
         $display("FAIL %s: got %03h expected %03h", tag, obs, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", 12'h000);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         wr_en          = VEC[i][23];
         wr_data        = VEC[i][22:15];
         auto_mode      = VEC[i][14];
         int_timer_mode = VEC[i][13];
         timer_cfg_wr   = VEC[i][12];
         @(negedge clk);
         check(tag_of(i), VEC[i][11:0]);
      end
      // R11: idle cycle after the poll clears the pulse, levels held
      wr_en = 1'b0; wr_data = 8'h00; int_timer_mode = 1'b0;
      @(negedge clk);
      check("R11 pulse self-clear", 12'h1AC);
      // R1: reset in mid-run clears all levels
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", 12'h000);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hang expected completion");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule